// File: doc/BRIEF.md
# Compound Conditional Branch Evaluator

This block decides whether a conditional jump is taken and produces the program counter the fetch stage should use next. It compares two register values and tests one status flag, then joins the two results under a rule chosen by the instruction. Operand reads from the register file and fetching the word after the instruction are done elsewhere. The block receives the finished values: both operands, their register indices, the flag vector, the current program counter and that following word.

The 6-bit extension field is split into three sub-fields. The lowest two bits pick the register comparison, the middle two pick the flag, and the top two pick how the two tests are joined. The low bit of the opcode chooses the target mode. In absolute mode the following word is the target. In relative mode the following word is added to the program counter, which already points at that word. A branch that is not taken steps the program counter by one word, past the target word.

The decision logic is combinational. Its result is captured in output registers on a cycle where the valid strobe is high, and the registers hold their contents at all other times.

Top module: `branch_eval`

## Requirements
- R1: While synchronous reset is high at a clock edge, both outputs are cleared after that edge: `taken_o` is 0 and `next_pc_o` is 0.
- R2: Extension bits [1:0] select the register comparison of operand A against operand B. Code 0 tests equal, code 1 tests not equal, code 2 tests signed A < B, and code 3 tests signed A <= B. Both operands are two's complement values.
- R3: When comparison code 0 is selected and the two register indices are identical, the comparison result is true whatever the operand values are.
- R4: Extension bits [3:2] select one bit of the 4-bit flag input as the flag test. Code 0 selects bit 0 (overflow), code 1 selects bit 1 (zero), code 2 selects bit 2 (sign), and code 3 selects bit 3 (parity).
- R5: Extension bits [5:4] select the merge rule, where C is the comparison result and F is the flag test. Code 0 gives C, code 1 gives C OR F, code 2 gives C AND NOT F, and code 3 gives C OR NOT F. The merged value is the taken decision.
- R6: A taken branch with opcode low bit 0 yields the following word as the next program counter.
- R7: A taken branch with opcode low bit 1 yields the current program counter plus the following word, modulo 2^PC_W.
- R8: A branch that is not taken yields the current program counter plus one, modulo 2^PC_W, for either target mode.
- R9: Both outputs take the result of the inputs present at the clock edge where `valid_i` is high. At an edge where `valid_i` is low, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe that loads a new decision |
| op_rel_i | input | 1 | Opcode low bit: 1 selects relative targeting |
| ext_i | input | 6 | Extension field: [1:0] compare, [3:2] flag, [5:4] merge |
| idx_a_i | input | IDX_W | Register index of operand A |
| idx_b_i | input | IDX_W | Register index of operand B |
| val_a_i | input | DATA_W | Operand A value |
| val_b_i | input | DATA_W | Operand B value |
| flags_i | input | 4 | Status flags: bit 0 overflow, 1 zero, 2 sign, 3 parity |
| pc_i | input | PC_W | Program counter, pointing at the target word |
| target_i | input | PC_W | Word following the instruction |
| taken_o | output | 1 | Registered taken decision |
| next_pc_o | output | PC_W | Registered next program counter |

## Verification
The bench builds the block with DATA_W=4, PC_W=6 and IDX_W=2.

- **Comparisons (R2, R3):** Four-bit operands allow every operand pair under every comparison code. This covers the signed wrap at the boundary between 7 and -8. Two-bit indices make both the same-index case and the different-index case cheap to reach.
- **Flag tests and merge rules (R4, R5):** The full 64-value extension field is crossed with all 16 flag vectors for several operand pairs.
- **Target modes (R6, R7, R8):** A 6-bit program counter allows every pair of program counter and target word in both target modes, taken and not taken. This covers the wraparound of the relative sum and of the one-word step.

// File: rtl/branch_eval_pkg.sv
package branch_eval_pkg;

    localparam int EXT_W  = 6;
    localparam int FLAG_N = 4;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_LT = 2'd2,
        CMP_LE = 2'd3
    } cmp_sel_e;

    typedef enum logic [1:0] {
        FSEL_OVF = 2'd0,
        FSEL_ZERO = 2'd1,
        FSEL_SIGN = 2'd2,
        FSEL_PAR = 2'd3
    } flag_sel_e;

    typedef enum logic [1:0] {
        MRG_PLAIN = 2'd0,
        MRG_OR    = 2'd1,
        MRG_ANDN  = 2'd2,
        MRG_ORN   = 2'd3
    } merge_e;

    // Field layout of the extension word, most significant field first.
    typedef struct packed {
        merge_e    merge;
        flag_sel_e fsel;
        cmp_sel_e  cmp;
    } ext_t;

    // Flag vector, bit 0 is overflow.
    typedef struct packed {
        logic parity;
        logic sign;
        logic zero;
        logic ovf;
    } flags_t;

    function automatic logic merge_tests(merge_e rule, logic cmp_hit, logic flag_hit);
        logic r;
        unique case (rule)
            MRG_PLAIN: r = cmp_hit;
            MRG_OR:    r = cmp_hit | flag_hit;
            MRG_ANDN:  r = cmp_hit & ~flag_hit;
            MRG_ORN:   r = cmp_hit | ~flag_hit;
            default:   r = cmp_hit;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/branch_cmp.sv
module branch_cmp
    import branch_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  cmp_sel_e          sel_i,
    input  logic [IDX_W-1:0]  idx_a_i,
    input  logic [IDX_W-1:0]  idx_b_i,
    input  logic [DATA_W-1:0] val_a_i,
    input  logic [DATA_W-1:0] val_b_i,
    output logic              hit_o
);

    logic same_reg;
    logic eq_v;
    logic lt_v;

    assign same_reg = (idx_a_i == idx_b_i);
    assign eq_v     = (val_a_i == val_b_i);
    assign lt_v     = ($signed(val_a_i) < $signed(val_b_i));

    always_comb begin
        unique case (sel_i)
            CMP_EQ:  hit_o = same_reg | eq_v;
            CMP_NE:  hit_o = ~eq_v;
            CMP_LT:  hit_o = lt_v;
            CMP_LE:  hit_o = lt_v | eq_v;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_flag_merge.sv
module branch_flag_merge
    import branch_eval_pkg::*;
(
    input  flags_t    flags_i,
    input  flag_sel_e fsel_i,
    input  merge_e    merge_i,
    input  logic      cmp_hit_i,
    output logic      taken_o
);

    logic [FLAG_N-1:0] flag_vec;
    logic              flag_hit;

    assign flag_vec = flags_i;
    assign flag_hit = flag_vec[fsel_i];
    assign taken_o  = merge_tests(merge_i, cmp_hit_i, flag_hit);

endmodule

// File: rtl/branch_target.sv
module branch_target #(
    parameter int PC_W = 32
) (
    input  logic            taken_i,
    input  logic            rel_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] next_pc_o
);

    localparam logic [PC_W-1:0] ONE_WORD = PC_W'(1);

    logic            use_adder;
    logic [PC_W-1:0] addend;
    logic [PC_W-1:0] sum;

    // One shared adder serves both the relative target and the fall-through step.
    assign use_adder = ~taken_i | rel_i;
    assign addend    = taken_i ? target_i : ONE_WORD;
    assign sum       = pc_i + addend;
    assign next_pc_o = use_adder ? sum : target_i;

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import branch_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              op_rel_i,
    input  logic [5:0]        ext_i,
    input  logic [IDX_W-1:0]  idx_a_i,
    input  logic [IDX_W-1:0]  idx_b_i,
    input  logic [DATA_W-1:0] val_a_i,
    input  logic [DATA_W-1:0] val_b_i,
    input  logic [3:0]        flags_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   target_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o
);

    ext_t            ext;
    logic            cmp_hit;
    logic            taken_c;
    logic [PC_W-1:0] next_pc_c;

    assign ext = ext_t'(ext_i);

    branch_cmp #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_cmp (
        .sel_i   (ext.cmp),
        .idx_a_i (idx_a_i),
        .idx_b_i (idx_b_i),
        .val_a_i (val_a_i),
        .val_b_i (val_b_i),
        .hit_o   (cmp_hit)
    );

    branch_flag_merge u_merge (
        .flags_i   (flags_t'(flags_i)),
        .fsel_i    (ext.fsel),
        .merge_i   (ext.merge),
        .cmp_hit_i (cmp_hit),
        .taken_o   (taken_c)
    );

    branch_target #(
        .PC_W (PC_W)
    ) u_target (
        .taken_i   (taken_c),
        .rel_i     (op_rel_i),
        .pc_i      (pc_i),
        .target_i  (target_i),
        .next_pc_o (next_pc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else if (valid_i) begin
            taken_o   <= taken_c;
            next_pc_o <= next_pc_c;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!taken_o && next_pc_o == '0));

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(taken_o) && $stable(next_pc_o)));

    // R3
    same_reg_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ext_i[1:0] == 2'd0 && ext_i[5:4] != 2'd2 && idx_a_i == idx_b_i)
        |=> taken_o);

    // R8
    not_taken_step_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'(1)));

    // R6
    abs_target_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !op_rel_i) |=> (!taken_o || next_pc_o == $past(target_i)));

    // R5
    or_flag_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ext_i[5:4] == 2'd1 && flags_i[ext_i[3:2]]) |=> taken_o);

endmodule

// File: tb/tb_branch_eval.sv
module tb_branch_eval;

    localparam int DW = 4;
    localparam int PW = 6;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_i;
    logic          op_rel_i;
    logic [5:0]    ext_i;
    logic [IW-1:0] idx_a_i, idx_b_i;
    logic [DW-1:0] val_a_i, val_b_i;
    logic [3:0]    flags_i;
    logic [PW-1:0] pc_i, target_i;
    logic          taken_o;
    logic [PW-1:0] next_pc_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    branch_eval #(.DATA_W(DW), .PC_W(PW), .IDX_W(IW)) dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_rel_i(op_rel_i),
        .ext_i(ext_i), .idx_a_i(idx_a_i), .idx_b_i(idx_b_i),
        .val_a_i(val_a_i), .val_b_i(val_b_i), .flags_i(flags_i),
        .pc_i(pc_i), .target_i(target_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o)
    );

    function automatic int sval(int v);
        return (v >= (1 << (DW - 1))) ? v - (1 << DW) : v;
    endfunction

    function automatic bit ref_cmp(int code, int ia, int ib, int a, int b);
        case (code)
            0: return (ia == ib) || (a == b);
            1: return a != b;
            2: return sval(a) < sval(b);
            default: return sval(a) <= sval(b);
        endcase
    endfunction

    function automatic bit ref_taken(int ext, int ia, int ib, int a, int b, int fl);
        bit c, f;
        c = ref_cmp(ext % 4, ia, ib, a, b);
        f = ((fl >> ((ext / 4) % 4)) & 1) != 0;
        case (ext / 16)
            0: return c;
            1: return c | f;
            2: return c & !f;
            default: return c | !f;
        endcase
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d (ext=%0d a=%0d b=%0d fl=%0d pc=%0d tgt=%0d)",
                     req, got, exp, ext_i, val_a_i, val_b_i, flags_i, pc_i, target_i);
        end
    endtask

    task automatic apply(bit rel, int ext, int ia, int ib, int a, int b, int fl, int pc, int tg);
        @(negedge clk);
        valid_i  = 1'b1;
        op_rel_i = rel;
        ext_i    = 6'(ext);
        idx_a_i  = IW'(ia);
        idx_b_i  = IW'(ib);
        val_a_i  = DW'(a);
        val_b_i  = DW'(b);
        flags_i  = 4'(fl);
        pc_i     = PW'(pc);
        target_i = PW'(tg);
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; op_rel_i = 1'b0; ext_i = '0;
        idx_a_i = '0; idx_b_i = '0; val_a_i = '0; val_b_i = '0;
        flags_i = '0; pc_i = '0; target_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 taken", int'(taken_o), 0);
        check("R1 next_pc", int'(next_pc_o), 0);
        rst = 1'b0;

        // R2, R3: every operand pair under every comparison, merge mode 0
        for (int code = 0; code < 4; code++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int same = 0; same < 2; same++) begin
                        apply(1'b0, code, 1, same ? 1 : 2, a, b, 0, 10, 40);
                        check(same ? "R3 same-index compare" : "R2 compare", int'(taken_o),
                              int'(ref_cmp(code, 1, same ? 1 : 2, a, b)));
                    end

        // R4, R5: full extension field crossed with all flag vectors
        for (int p = 0; p < 3; p++)
            for (int ext = 0; ext < 64; ext++)
                for (int fl = 0; fl < 16; fl++) begin
                    int a, b;
                    a = (p == 0) ? 3 : (p == 1) ? 9 : 5;
                    b = (p == 0) ? 3 : (p == 1) ? 2 : 12;
                    apply(1'b0, ext, 0, 3, a, b, fl, 20, 50);
                    check("R4 R5 merge", int'(taken_o), int'(ref_taken(ext, 0, 3, a, b, fl)));
                end

        // R6, R7, R8: next program counter for every pc and target word
        for (int pc = 0; pc < 64; pc++)
            for (int tg = 0; tg < 64; tg++)
                for (int rel = 0; rel < 2; rel++) begin
                    // taken: equality with the same index
                    apply(rel[0], 0, 2, 2, 1, 5, 0, pc, tg);
                    check(rel ? "R7 relative" : "R6 absolute", int'(next_pc_o),
                          rel ? (pc + tg) % 64 : tg);
                    // not taken: not-equal with equal values
                    apply(rel[0], 1, 0, 1, 7, 7, 0, pc, tg);
                    check("R8 fall-through", int'(next_pc_o), (pc + 1) % 64);
                end

        // R9: hold while valid is low
        apply(1'b1, 0, 3, 3, 0, 0, 0, 30, 5);
        check("R9 load", int'(next_pc_o), 35);
        ext_i = 6'd1; val_a_i = 4'd1; pc_i = 6'd2; target_i = 6'd9; op_rel_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 hold next_pc", int'(next_pc_o), 35);
        check("R9 hold taken", int'(taken_o), 1);

        // R1: reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset taken", int'(taken_o), 0);
        check("R1 re-reset next_pc", int'(next_pc_o), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule